// File: doc/BRIEF.md
# Pipelined Pre-Add Multiply-Accumulate Slice

This block is a signed arithmetic slice for filter and dot-product datapaths. Two narrow operands are first summed or differenced in a pre-adder. The pre-adder result, or one of its operands passed straight through, is multiplied by a third narrow operand. The full-precision product is sign-extended and added to a selectable wide operand.

The wide operand can be zero, an external value, the slice's own result (running accumulation) or a cascade input from a neighbouring slice. Every stage is separated by registers, four in total. The result is also driven onto a cascade output, so slices can be chained into wider sums.

A 4-bit mode word travels down the pipeline with its data, so each vector is processed under the mode it was presented with. One clock enable freezes the whole pipe. A synchronous reset empties it.

Top module: `mac_preadd_slice`

## Requirements
- R1: A vector presented on the inputs while `ce` is high appears on `p` right after the fourth enabled rising edge that follows, counting the edge that captures it; earlier edges show older results.
- R2: With mode bit 0 set, the pre-adder forms `d + b` (mode bit 1 clear) or `d - b` (mode bit 1 set), both wrapping modulo 2^18 as 18-bit two's-complement values.
- R3: With mode bit 0 clear, the multiplier's first operand is `b` unchanged and `d` and mode bit 1 have no effect on the result.
- R4: The multiplier forms the signed 36-bit product of the pre-adder output and `a`, and the product is sign-extended to 48 bits before the final add. This holds for (-2^17)·(-2^17) = 2^34.
- R5: Mode bits [3:2] = 00 select zero as the final addend, so `p` is the extended product alone.
- R6: Mode bits [3:2] = 01 select `c`, as presented together with the same vector; the 48-bit sum wraps modulo 2^48.
- R7: Mode bits [3:2] = 10 select the current value of `p`, so consecutive vectors accumulate.
- R8: Mode bits [3:2] = 11 select `pcin` as present at the edge that writes the result, and `pcout` always carries the same value as `p`.
- R9: While `ce` is low, every pipeline stage holds, `p` does not change, and work resumes from the same point once `ce` returns high.
- R10: `rst` high at a rising edge clears every pipeline stage, so `p` reads zero after that edge and emptied stages contribute zero products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every stage |
| op | input | 4 | Mode: [0] pre-adder on, [1] subtract, [3:2] final addend select |
| a | input | 18 | Signed multiplier operand |
| b | input | 18 | Signed pre-adder operand / bypass operand |
| d | input | 18 | Signed pre-adder operand |
| c | input | 48 | External addend |
| pcin | input | 48 | Cascade addend from a neighbouring slice |
| p | output | 48 | Registered result |
| pcout | output | 48 | Cascade copy of the result |

## Verification
The bench builds the slice with its default widths (18-bit operands, 48-bit accumulator) and the pre-adder enabled. These are the widths at which the pre-adder's wrap at ±2^17 and the squared most-negative operand can be reached by directed vectors. An all-ones `c` plus a small product also drives the 48-bit sum through its wrap. Random vectors biased towards the extreme operand values interleave all four addend selections with stalls and occasional resets, so accumulation crosses mode changes and pipeline freezes.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      Z_ZERO = 2'd0,
      Z_EXT  = 2'd1,
      Z_ACC  = 2'd2,
      Z_CASC = 2'd3
   } zsel_e;

   typedef struct packed {
      zsel_e zsel;
      logic  sub;
      logic  pre_en;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
   import mac_pkg::*;
#(
   parameter int A_W   = 18,
   parameter int B_W   = 18,
   parameter int ACC_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  mode_t            m_in,
   input  logic [A_W-1:0]   a_in,
   input  logic [B_W-1:0]   b_in,
   input  logic [B_W-1:0]   d_in,
   input  logic [ACC_W-1:0] c_in,
   output mode_t            m1,
   output logic [A_W-1:0]   a1,
   output logic [B_W-1:0]   b1,
   output logic [B_W-1:0]   d1,
   output logic [ACC_W-1:0] c1
);
   always_ff @(posedge clk) begin
      if (rst) begin
         m1 <= '0;
         a1 <= '0;
         b1 <= '0;
         d1 <= '0;
         c1 <= '0;
      end else if (ce) begin
         m1 <= m_in;
         a1 <= a_in;
         b1 <= b_in;
         d1 <= d_in;
         c1 <= c_in;
      end
   end

   assert_in_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(a1) && $stable(b1) && $stable(d1) && $stable(c1)));
endmodule

// File: rtl/mac_preadd_stage.sv
module mac_preadd_stage
   import mac_pkg::*;
#(
   parameter int A_W       = 18,
   parameter int B_W       = 18,
   parameter int ACC_W     = 48,
   parameter bit PREADD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  mode_t            m1,
   input  logic [A_W-1:0]   a1,
   input  logic [B_W-1:0]   b1,
   input  logic [B_W-1:0]   d1,
   input  logic [ACC_W-1:0] c1,
   output zsel_e            z2,
   output logic [A_W-1:0]   a2,
   output logic [B_W-1:0]   pre2,
   output logic [ACC_W-1:0] c2
);
   logic [B_W-1:0] pre_c;

   generate
      if (PREADD_EN) begin : g_preadd
         always_comb begin
            if (!m1.pre_en)   pre_c = b1;
            else if (m1.sub)  pre_c = d1 - b1;
            else              pre_c = d1 + b1;
         end
      end else begin : g_bypass_only
         assign pre_c = b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         z2   <= Z_ZERO;
         a2   <= '0;
         pre2 <= '0;
         c2   <= '0;
      end else if (ce) begin
         z2   <= m1.zsel;
         a2   <= a1;
         pre2 <= pre_c;
         c2   <= c1;
      end
   end

   assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
      (ce && !m1.pre_en) |=> (pre2 == $past(b1)));

   assert_add_zero_R2: assert property (@(posedge clk) disable iff (rst)
      (ce && m1.pre_en && !m1.sub && (b1 == '0)) |=> (pre2 == $past(d1)));
endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
   import mac_pkg::*;
#(
   parameter int A_W   = 18,
   parameter int B_W   = 18,
   parameter int ACC_W = 48,
   localparam int PROD_W = A_W + B_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  zsel_e             z2,
   input  logic [A_W-1:0]    a2,
   input  logic [B_W-1:0]    pre2,
   input  logic [ACC_W-1:0]  c2,
   output zsel_e             z3,
   output logic [PROD_W-1:0] prod3,
   output logic [ACC_W-1:0]  c3
);
   logic [PROD_W-1:0] pre_x, a_x, prod_c;

   assign pre_x  = {{A_W{pre2[B_W-1]}}, pre2};
   assign a_x    = {{B_W{a2[A_W-1]}}, a2};
   assign prod_c = pre_x * a_x;

   always_ff @(posedge clk) begin
      if (rst) begin
         z3    <= Z_ZERO;
         prod3 <= '0;
         c3    <= '0;
      end else if (ce) begin
         z3    <= z2;
         prod3 <= prod_c;
         c3    <= c2;
      end
   end

   assert_zero_factor_R4: assert property (@(posedge clk) disable iff (rst)
      (ce && ((pre2 == '0) || (a2 == '0))) |=> (prod3 == '0));

   assert_neg_sign_R4: assert property (@(posedge clk) disable iff (rst)
      (ce && (pre2 != '0) && (a2 != '0) && (pre2[B_W-1] != a2[A_W-1]))
      |=> prod3[PROD_W-1]);
endmodule

// File: rtl/mac_post_stage.sv
module mac_post_stage
   import mac_pkg::*;
#(
   parameter int A_W   = 18,
   parameter int B_W   = 18,
   parameter int ACC_W = 48,
   localparam int PROD_W = A_W + B_W,
   localparam int EXT_W  = ACC_W - PROD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce,
   input  zsel_e             z3,
   input  logic [PROD_W-1:0] prod3,
   input  logic [ACC_W-1:0]  c3,
   input  logic [ACC_W-1:0]  pcin,
   output logic [ACC_W-1:0]  p
);
   logic [ACC_W-1:0] prod_ext, addend, sum_c;

   assign prod_ext = {{EXT_W{prod3[PROD_W-1]}}, prod3};

   always_comb begin
      unique case (z3)
         Z_ZERO:  addend = '0;
         Z_EXT:   addend = c3;
         Z_ACC:   addend = p;
         default: addend = pcin;
      endcase
   end

   assign sum_c = prod_ext + addend;

   always_ff @(posedge clk) begin
      if (rst)     p <= '0;
      else if (ce) p <= sum_c;
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(p));

   assert_reset_R10: assert property (@(posedge clk)
      rst |=> (p == '0));

   assert_zero_sel_R5: assert property (@(posedge clk) disable iff (rst)
      (ce && (z3 == Z_ZERO) && (prod3 == '0)) |=> (p == '0));

   assert_accum_keep_R7: assert property (@(posedge clk) disable iff (rst)
      (ce && (z3 == Z_ACC) && (prod3 == '0)) |=> $stable(p));
endmodule

// File: rtl/mac_preadd_slice.sv
module mac_preadd_slice
   import mac_pkg::*;
#(
   parameter int A_W       = 18,
   parameter int B_W       = 18,
   parameter int ACC_W     = 48,
   parameter bit PREADD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic [3:0]       op,
   input  logic [A_W-1:0]   a,
   input  logic [B_W-1:0]   b,
   input  logic [B_W-1:0]   d,
   input  logic [ACC_W-1:0] c,
   input  logic [ACC_W-1:0] pcin,
   output logic [ACC_W-1:0] p,
   output logic [ACC_W-1:0] pcout
);
   localparam int PROD_W = A_W + B_W;

   generate
      if (A_W < 2 || B_W < 2) begin : g_bad_operand
         $error("mac_preadd_slice: operand widths must be at least 2");
      end
      if (ACC_W <= PROD_W) begin : g_bad_acc
         $error("mac_preadd_slice: ACC_W must exceed A_W + B_W");
      end
      if (MODE_W != 4) begin : g_bad_mode
         $error("mac_preadd_slice: mode word must be 4 bits");
      end
   endgenerate

   mode_t             m1;
   zsel_e             z2, z3;
   logic [A_W-1:0]    a1, a2;
   logic [B_W-1:0]    b1, d1, pre2;
   logic [ACC_W-1:0]  c1, c2, c3;
   logic [PROD_W-1:0] prod3;

   mac_in_stage #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_s1 (
      .clk(clk), .rst(rst), .ce(ce), .m_in(mode_t'(op)),
      .a_in(a), .b_in(b), .d_in(d), .c_in(c),
      .m1(m1), .a1(a1), .b1(b1), .d1(d1), .c1(c1)
   );

   mac_preadd_stage #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .PREADD_EN(PREADD_EN)) u_s2 (
      .clk(clk), .rst(rst), .ce(ce), .m1(m1), .a1(a1), .b1(b1), .d1(d1), .c1(c1),
      .z2(z2), .a2(a2), .pre2(pre2), .c2(c2)
   );

   mac_mul_stage #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_s3 (
      .clk(clk), .rst(rst), .ce(ce), .z2(z2), .a2(a2), .pre2(pre2), .c2(c2),
      .z3(z3), .prod3(prod3), .c3(c3)
   );

   mac_post_stage #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_s4 (
      .clk(clk), .rst(rst), .ce(ce), .z3(z3), .prod3(prod3), .c3(c3),
      .pcin(pcin), .p(p)
   );

   assign pcout = p;
endmodule

// File: tb/mac_preadd_slice_test.sv
`timescale 1ns/1ps
module mac_preadd_slice_test;
   typedef struct packed {
      logic [17:0] a;
      logic [17:0] b;
      logic [17:0] d;
      logic [47:0] c;
      logic [3:0]  op;
   } ent_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce = 1'b0;
   logic [3:0]  op = '0;
   logic [17:0] a = '0, b = '0, d = '0;
   logic [47:0] c = '0, pcin = '0;
   logic [47:0] p, pcout;

   int nchk = 0;
   int nfail = 0;
   ent_t q1 = '0, q2 = '0, q3 = '0;
   logic [47:0] mp = '0;

   always #2.5 clk = ~clk;

   mac_preadd_slice uut (
      .clk(clk), .rst(rst), .ce(ce), .op(op), .a(a), .b(b), .d(d),
      .c(c), .pcin(pcin), .p(p), .pcout(pcout)
   );

   function automatic logic [35:0] prod_of(input ent_t e);
      logic [17:0] pre;
      longint r;
      if (e.op[0]) pre = e.op[1] ? (e.d - e.b) : (e.d + e.b);
      else         pre = e.b;
      r = longint'($signed(pre)) * longint'($signed(e.a));
      return r[35:0];
   endfunction

   function automatic logic [47:0] post_of(input ent_t e, input logic [47:0] prev,
                                            input logic [47:0] pc);
      longint ex;
      logic [47:0] z;
      ex = longint'($signed(prod_of(e)));
      case (e.op[3:2])
         2'b00:   z = '0;
         2'b01:   z = e.c;
         2'b10:   z = prev;
         default: z = pc;
      endcase
      return ex[47:0] + z;
   endfunction

   task automatic step(input logic [17:0] ia, input logic [17:0] ib, input logic [17:0] id,
                       input logic [47:0] ic, input logic [47:0] ipc, input logic [3:0] iop,
                       input logic ice, input logic irst, input string tag);
      a = ia; b = ib; d = id; c = ic; pcin = ipc; op = iop; ce = ice; rst = irst;
      @(posedge clk);
      if (irst) begin
         q1 = '0; q2 = '0; q3 = '0; mp = '0;
      end else if (ice) begin
         mp = post_of(q3, mp, ipc);
         q3 = q2; q2 = q1;
         q1 = '{a: ia, b: ib, d: id, c: ic, op: iop};
      end
      @(negedge clk);
      nchk++;
      if (p !== mp || pcout !== mp) begin
         nfail++;
         $display("FAIL %s: p=%h pcout=%h expected %h", tag, p, pcout, mp);
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int k = 0; k < n; k++) step('0, '0, '0, '0, '0, 4'b0000, 1'b1, 1'b0, tag);
   endtask

   function automatic logic [17:0] pick18();
      case ($urandom % 6)
         0:       return 18'h1FFFF;
         1:       return 18'h20000;
         2:       return 18'h00000;
         3:       return 18'h3FFFF;
         default: return 18'($urandom);
      endcase
   endfunction

   initial begin
      #(5.0 * 190000);
      nfail++;
      $display("FAIL watchdog R1: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R10: reset state
      step('0, '0, '0, '0, '0, 4'b0000, 1'b0, 1'b1, "R10 reset");
      step('0, '0, '0, '0, '0, 4'b0000, 1'b0, 1'b1, "R10 reset");
      // R1: (5+2)*3 = 21 appears after the fourth enabled edge
      step(18'd3, 18'd2, 18'd5, '0, '0, 4'b0001, 1'b1, 1'b0, "R1 latency");
      idle(3, "R1 latency");
      // R2: add wraps to -2^17, subtract wraps to 2^17-1
      step(18'd1, 18'd1, 18'h1FFFF, '0, '0, 4'b0001, 1'b1, 1'b0, "R2 add wrap");
      step(18'd1, 18'd1, 18'h20000, '0, '0, 4'b0011, 1'b1, 1'b0, "R2 sub wrap");
      step(18'd2, 18'd9, 18'd4, '0, '0, 4'b0011, 1'b1, 1'b0, "R2 sub");
      idle(3, "R2 flush");
      // R3: bypass, d and subtract bit ignored
      step(18'd7, 18'h3FFFB, 18'd999, '0, '0, 4'b0010, 1'b1, 1'b0, "R3 bypass");
      idle(3, "R3 flush");
      // R4: most negative squared, and mixed-sign extremes
      step(18'h20000, 18'h20000, '0, '0, '0, 4'b0000, 1'b1, 1'b0, "R4 min squared");
      step(18'h20000, 18'h1FFFF, '0, '0, '0, 4'b0000, 1'b1, 1'b0, "R4 min times max");
      idle(3, "R4 flush");
      // R5/R6: zero vs external addend, with 48-bit wrap
      step(18'd3, 18'd7, '0, 48'hFFFF_FFFF_FFFF, '0, 4'b0000, 1'b1, 1'b0, "R5 zero addend");
      step(18'd3, 18'd7, '0, 48'hFFFF_FFFF_FFFF, '0, 4'b0100, 1'b1, 1'b0, "R6 ext wrap");
      step(18'h3FFFF, 18'd5, '0, 48'h7FFF_0000_0001, '0, 4'b0100, 1'b1, 1'b0, "R6 ext");
      idle(3, "R6 flush");
      // R7: running accumulation of 10 per vector
      for (int k = 0; k < 6; k++) step(18'd1, 18'd10, '0, '0, '0, 4'b1000, 1'b1, 1'b0, "R7 accumulate");
      for (int k = 0; k < 4; k++) step('0, '0, '0, '0, '0, 4'b1000, 1'b1, 1'b0, "R7 accumulate hold");
      // R8: cascade addend sampled at the writing edge
      for (int k = 0; k < 6; k++)
         step(18'd2, 18'd3, '0, '0, 48'h0000_1234_5678 + 48'(k), 4'b1100, 1'b1, 1'b0, "R8 cascade");
      // R9: stall with changing inputs, then resume
      step(18'd4, 18'd4, '0, '0, '0, 4'b1000, 1'b1, 1'b0, "R9 prime");
      for (int k = 0; k < 5; k++)
         step(18'($urandom), 18'($urandom), 18'($urandom), 48'hABCD, 48'h55, 4'($urandom),
              1'b0, 1'b0, "R9 stall");
      idle(4, "R9 resume");
      // R10: reset in the middle of a stream
      step(18'd9, 18'd9, '0, '0, '0, 4'b0000, 1'b1, 1'b0, "R10 prime");
      step(18'd9, 18'd9, '0, '0, '0, 4'b0000, 1'b1, 1'b0, "R10 prime");
      step(18'd9, 18'd9, '0, '0, '0, 4'b0000, 1'b1, 1'b1, "R10 mid reset");
      idle(4, "R10 emptied");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] rop;
         string tg;
         rop = 4'($urandom);
         case (rop[3:2])
            2'b00:   tg = "R5 random";
            2'b01:   tg = "R6 random";
            2'b10:   tg = "R7 random";
            default: tg = "R8 random";
         endcase
         step(pick18(), pick18(), pick18(), {16'($urandom), 32'($urandom)},
              {16'($urandom), 32'($urandom)}, rop,
              (($urandom % 8) != 0), (($urandom % 700) == 0), tg);
      end
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule